// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps external events. A free-running counter advances once per clock while a run bit is set. Two independent channels, A and B, each watch one asynchronous trigger input. After synchronization, a channel that is in capture mode and sees its selected edge copies the counter value into its own capture register and raises its done flag. Software can measure periods and pulse widths by subtracting two captured values.

Each channel also keeps an overwrite flag. That flag is set when a fresh capture replaces data whose done flag is still up, which means software has not yet acknowledged the older value. A small register interface holds the run and counter-clear controls, the per-channel mode bits and edge selects, and three interrupt enables. It also gives read access to the counter and both capture registers, and write-one-to-clear access to the flags. All interrupt sources are merged by OR onto one request line. The compare output exists only as a port that stays low.

Register map (`reg_addr`): 0 control, 1 interrupt enables, 2 flags, 3 counter value, 4 capture A, 5 capture B. Reads are combinational. Writes take effect on the clock edge where `reg_wr` is high.

Top module: `tmr_capture_unit`

## Requirements
- R1: When a channel's mode bit is 0 (control bit 2 for A, bit 3 for B), that channel never captures and never sets a flag, whatever its edge select.
- R2: Each channel's two-bit edge select (control bits 5:4 for A, 7:6 for B) works as follows: 0 gives no trigger, 1 the rising edge, 2 the falling edge, 3 both edges. An edge that is not selected changes neither the capture register nor the flags.
- R3: A selected edge captures only while the run bit (control bit 0) is 1. The trigger passes through a two-flop synchronizer, and the capture happens on the third clock edge after the input changes. The value stored is the counter value in the cycle before that edge. The same edge sets the channel's done flag (flags bit 0 for A, bit 1 for B).
- R4: A capture that lands while the channel's done flag is already 1 sets its overwrite flag (flags bit 2 for A, bit 3 for B).
- R5: `irq` is 1 exactly when at least one of these holds: the A done flag is set with enable bit 0; the B done flag is set with enable bit 1; either overwrite flag is set with enable bit 2.
- R6: `cmp_out` is 0 at all times.
- R7: While run is 1, the counter rises by one every clock and wraps from all ones to 0 without stopping. Writing control bit 1 as 1 loads 0, and counting continues from there on the following clocks.
- R8: Writing 1 to a flag bit clears that flag. A bit written as 0 leaves its flag unchanged. If a capture sets a flag in the same cycle as a clear of that flag, the flag ends up set.
- R9: After reset, control, enables, flags, counter and capture registers all read 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` |
| trig_a | input | 1 | Channel A trigger, asynchronous |
| trig_b | input | 1 | Channel B trigger, asynchronous |
| irq | output | 1 | Combined interrupt request |
| cmp_out | output | 1 | Compare output, held low |

## Verification
The capture path is exercised with rising-only, falling-only and both-edge selects. Trigger changes are placed a different number of cycles after a counter clear, so each captured value shows the synchronizer latency and also shows which capture was the last to land. Unselected edges, mode 0 and a stopped counter are each driven with real edges, to show that the gating blocks them rather than a quiet input. Back-to-back captures, partial flag clears and a clear that coincides with a capture separate the done, overwrite and interrupt logic. A run of more than 65536 cycles confirms that the counter wraps and keeps going.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_IEN  = 3'd1;
  localparam logic [2:0] ADDR_FLAG = 3'd2;
  localparam logic [2:0] ADDR_CNT  = 3'd3;
  localparam logic [2:0] ADDR_CAP0 = 3'd4;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_CLR  = 1;
  localparam int CTRL_MODE = 2;  // + channel
  localparam int CTRL_EDGE = 4;  // + 2*channel
  localparam int IEN_OVR   = NCH;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din,
  input  edge_sel_e sel,
  output logic      hit
);
  logic s1_q, s2_q, prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             hit,
  input  logic [CNT_W-1:0] cnt,
  input  logic             clr_cap,
  input  logic             clr_ovr,
  output logic [CNT_W-1:0] cap_q,
  output logic             cap_flag_q,
  output logic             ovr_flag_q
);
  logic             evt;
  logic [CNT_W-1:0] cap_d;
  logic             cap_flag_d, ovr_flag_d;

  assign evt = armed & hit;

  always_comb begin
    cap_d      = evt ? cnt : cap_q;
    cap_flag_d = evt | (cap_flag_q & ~clr_cap);
    ovr_flag_d = (evt & cap_flag_q) | (ovr_flag_q & ~clr_ovr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q      <= '0;
      cap_flag_q <= 1'b0;
      ovr_flag_q <= 1'b0;
    end else begin
      cap_q      <= cap_d;
      cap_flag_q <= cap_flag_d;
      ovr_flag_q <= ovr_flag_d;
    end
  end

  // R3: capture takes the counter value and raises the done flag
  a_r3_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cap_q == $past(cnt)) && cap_flag_q);
  // R4: capture over an unacknowledged value marks overwrite
  a_r4_overwrite_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cap_flag_q) |=> ovr_flag_q);
  // R8: set beats a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr_cap) |=> cap_flag_q);
  // R1: a disarmed channel keeps its captured value
  a_r1_disarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(cap_q));
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import cap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             trig_a,
  input  logic             trig_b,
  output logic             irq,
  output logic             cmp_out
);
  localparam int IEN_W = NCH + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // control state
  logic             run_q, run_d;
  logic [NCH-1:0]   mode_q, mode_d;
  edge_sel_e        esel_q [NCH];
  edge_sel_e        esel_d [NCH];
  logic [IEN_W-1:0] ien_q, ien_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_ctrl, wr_ien, wr_flag, cnt_clr;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_ien  = reg_wr && (reg_addr == ADDR_IEN);
  assign wr_flag = reg_wr && (reg_addr == ADDR_FLAG);
  assign cnt_clr = wr_ctrl && reg_wdata[CTRL_CLR];

  always_comb begin
    run_d  = run_q;
    mode_d = mode_q;
    ien_d  = ien_q;
    for (int i = 0; i < NCH; i++) esel_d[i] = esel_q[i];
    if (wr_ctrl) begin
      run_d = reg_wdata[CTRL_RUN];
      for (int i = 0; i < NCH; i++) begin
        mode_d[i] = reg_wdata[CTRL_MODE + i];
        esel_d[i] = edge_sel_e'(reg_wdata[CTRL_EDGE + 2*i +: 2]);
      end
    end
    if (wr_ien) ien_d = reg_wdata[IEN_W-1:0];
    if (cnt_clr)    cnt_d = '0;
    else if (run_q) cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      run_q  <= 1'b0;
      mode_q <= '0;
      ien_q  <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < NCH; i++) esel_q[i] <= EDGE_NONE;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_d;
      ien_q  <= ien_d;
      cnt_q  <= cnt_d;
      for (int i = 0; i < NCH; i++) esel_q[i] <= esel_d[i];
    end
  end

  // channels
  logic [NCH-1:0]   trig_v, hit, cap_flag, ovr_flag;
  logic [CNT_W-1:0] cap_val [NCH];
  assign trig_v = {trig_b, trig_a};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cap_edge_det u_edge (
      .clk   (clk),
      .rst_n (rst_s_n),
      .din   (trig_v[g]),
      .sel   (esel_q[g]),
      .hit   (hit[g])
    );
    cap_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_s_n),
      .armed      (mode_q[g] & run_q),
      .hit        (hit[g]),
      .cnt        (cnt_q),
      .clr_cap    (wr_flag & reg_wdata[g]),
      .clr_ovr    (wr_flag & reg_wdata[NCH + g]),
      .cap_q      (cap_val[g]),
      .cap_flag_q (cap_flag[g]),
      .ovr_flag_q (ovr_flag[g])
    );
  end

  assign irq     = (|(cap_flag & ien_q[NCH-1:0])) | ((|ovr_flag) & ien_q[IEN_OVR]);
  assign cmp_out = 1'b0;

  // register read
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_RUN] = run_q;
        for (int i = 0; i < NCH; i++) begin
          reg_rdata[CTRL_MODE + i]         = mode_q[i];
          reg_rdata[CTRL_EDGE + 2*i +: 2]  = esel_q[i];
        end
      end
      ADDR_IEN:  reg_rdata[IEN_W-1:0] = ien_q;
      ADDR_FLAG: reg_rdata[2*NCH-1:0] = {ovr_flag, cap_flag};
      ADDR_CNT:  reg_rdata = REG_W'(cnt_q);
      ADDR_CAP0: reg_rdata = REG_W'(cap_val[0]);
      3'd5:      reg_rdata = REG_W'(cap_val[1]);
      default:   reg_rdata = '0;
    endcase
  end

  // R7: counting and clearing
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_q && !cnt_clr) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    cnt_clr |=> cnt_q == '0);
  // R5: no flag, no request
  a_r5_quiet_irq: assert property (@(posedge clk) disable iff (!rst_s_n)
    ({cap_flag, ovr_flag} == '0) |-> !irq);
  // R1: a channel in mode 0 never raises its done flag
  a_r1_mode_off: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mode_q[0] && !cap_flag[0]) |=> !cap_flag[0]);
endmodule

// File: tb/sim_tmr_capture_unit.sv
`timescale 1ns/100ps
module sim_tmr_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        trig_a, trig_b;
  logic        irq, cmp_out;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  tmr_capture_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_a(trig_a),
    .trig_b(trig_b), .irq(irq), .cmp_out(cmp_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write: strobe sampled on the next posedge; returns at the negedge after it
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [15:0] ctrl(input bit run, input bit clr, input bit ma,
                                       input bit mb, input logic [1:0] ea, input logic [1:0] eb);
    return {8'h00, eb, ea, mb, ma, clr, run};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [15:0] v;

  task automatic t_reset;
    rd(3'd0, v); chk("R9 ctrl", v, 0);
    rd(3'd1, v); chk("R9 ien", v, 0);
    rd(3'd2, v); chk("R9 flags", v, 0);
    rd(3'd3, v); chk("R9 count", v, 0);
    rd(3'd4, v); chk("R9 capA", v, 0);
    rd(3'd5, v); chk("R9 capB", v, 0);
    chk("R9 irq", irq, 0);
  endtask

  task automatic t_count;
    wr(3'd0, ctrl(1,1,0,0,0,0));
    wait_n(10);
    rd(3'd3, v); chk("R7 count after clear", v, 10);
    wr(3'd0, ctrl(1,1,0,0,0,0));
    wait_n(3);
    rd(3'd3, v); chk("R7 clear keeps running", v, 3);
    chk("R6 cmp_out", cmp_out, 0);
  endtask

  task automatic t_rise_a;
    wr(3'd1, 16'h0001);
    wr(3'd0, ctrl(1,1,1,0,2'd1,0));
    wait_n(4); trig_a = 1'b1;           // capture = 4 + 2
    wait_n(5);
    rd(3'd4, v); chk("R3 capA rising", v, 6);
    rd(3'd2, v); chk("R3 flagA", v, 16'h1);
    chk("R5 irq capA", irq, 1);
    trig_a = 1'b0;                       // falling edge, not selected
    wait_n(5);
    rd(3'd4, v); chk("R2 fall ignored capA", v, 6);
    rd(3'd2, v); chk("R2 fall ignored flags", v, 16'h1);
    wr(3'd2, 16'h000F);
    rd(3'd2, v); chk("R8 w1c all", v, 0);
    chk("R5 irq drops", irq, 0);
    chk("R6 cmp_out", cmp_out, 0);
  endtask

  task automatic t_fall_a;
    wr(3'd0, ctrl(1,1,1,0,2'd2,0));
    trig_a = 1'b1;                       // rising edge, not selected
    wait_n(5);
    rd(3'd2, v); chk("R2 rise ignored in fall mode", v, 0);
    wr(3'd0, ctrl(1,1,1,0,2'd2,0));
    wait_n(1); trig_a = 1'b0;           // capture = 3
    wait_n(5);
    rd(3'd4, v); chk("R2 capA falling", v, 3);
    rd(3'd2, v); chk("R3 flagA falling", v, 16'h1);
  endtask

  task automatic t_overwrite;
    wr(3'd1, 16'h0004);
    chk("R5 capA flag masked", irq, 0);
    wr(3'd0, ctrl(1,1,1,0,2'd3,0));
    wait_n(2); trig_a = 1'b1;           // capture = 4, flag already up
    wait_n(5);
    rd(3'd4, v); chk("R4 capA overwritten", v, 4);
    rd(3'd2, v); chk("R4 overwrite flag", v, 16'h5);
    chk("R5 irq overwrite", irq, 1);
    wr(3'd2, 16'h0001);
    rd(3'd2, v); chk("R8 partial clear", v, 16'h4);
    chk("R5 irq still overwrite", irq, 1);
    wr(3'd2, 16'h0004);
    rd(3'd2, v); chk("R8 clear overwrite", v, 0);
    chk("R5 irq cleared", irq, 0);
  endtask

  task automatic t_both_b;
    wr(3'd1, 16'h0002);
    wr(3'd0, ctrl(1,1,0,1,0,2'd3));
    trig_b = 1'b1;                       // capture = 2
    wait_n(5);
    rd(3'd5, v); chk("R2 capB both rise", v, 2);
    rd(3'd2, v); chk("R3 flagB", v, 16'h2);
    chk("R5 irq capB", irq, 1);
    wr(3'd2, 16'h0002);
    wr(3'd0, ctrl(1,1,0,1,0,2'd3));
    wait_n(5); trig_b = 1'b0;           // capture = 7
    wait_n(5);
    rd(3'd5, v); chk("R2 capB both fall", v, 7);
    rd(3'd2, v); chk("R3 flagB fall", v, 16'h2);
    wr(3'd2, 16'h0002);
  endtask

  task automatic t_set_wins;
    wr(3'd0, ctrl(1,1,0,1,0,2'd1));
    trig_b = 1'b1;                       // capture on third edge
    wait_n(2);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0002;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(3'd2, v); chk("R8 set wins over clear", v, 16'h2);
    rd(3'd5, v); chk("R8 capB value", v, 2);
    wr(3'd2, 16'h0002);
  endtask

  task automatic t_mode_off;
    wr(3'd0, ctrl(1,1,0,0,0,2'd3));
    trig_b = 1'b0;
    wait_n(6);
    rd(3'd2, v); chk("R1 mode0 no flag", v, 0);
    rd(3'd5, v); chk("R1 mode0 capB held", v, 2);
  endtask

  task automatic t_stopped;
    wr(3'd0, ctrl(0,1,1,0,2'd3,0));
    trig_a = 1'b0;
    wait_n(6);
    rd(3'd2, v); chk("R3 stopped no flag", v, 0);
    rd(3'd4, v); chk("R3 stopped capA held", v, 4);
    chk("R6 cmp_out", cmp_out, 0);
  endtask

  task automatic t_wrap;
    wr(3'd0, ctrl(1,1,0,0,0,0));
    wait_n(65536 + 7);
    rd(3'd3, v); chk("R7 wrap continues", v, 7);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 16'h0;
    trig_a = 1'b0; trig_b = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_count();
    t_rise_a();
    t_fall_a();
    t_overwrite();
    t_both_b();
    t_set_wins();
    t_mode_off();
    t_stopped();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule